// File: doc/BRIEF.md
# Register-Addressed EEPROM Transfer Sequencer

This block runs complete block reads and block writes against a two-wire serial target that is addressed by a 7-bit device address and a one-byte register offset. It does not drive the bus wires. Every bus action is handed to a byte engine as a single command: write a byte, optionally preceded by a START; read a byte with a chosen acknowledge; or send a STOP. The engine reports completion and the acknowledge it saw. Read data leaves the block on a byte stream. Write data comes into the block through a valid/ready handshake.

A read sends the device address for writing and then the offset. After a programmable idle gap it issues a repeated START with the device address for reading, and then clocks in the requested number of bytes. A write is cut into chunks of at most four bytes. Each chunk opens with its own addressing, and the offset advances by the bytes already written. After each chunk the block polls the device until the internal write cycle has finished. The poll is a START plus the read address; each poll that is refused is closed with a STOP and retried. Once a poll is accepted, one throw-away byte is read. A legacy mode serves targets that take the offset in place of the device byte: the first byte after START carries the offset in bits 7:1 and the direction in bit 0, and no separate offset byte follows.

Top module: `eetc_xfer`

## Requirements
- R1: While rst_n is low at a clock edge, eng_req, wdata_ready, rdata_valid, done and error are all 0 after that edge.
- R2: Each command is presented on eng_op (0 = write byte, 1 = read byte, 2 = STOP), eng_start, eng_tx and eng_ack_out. All of them are held unchanged with eng_req high until a cycle with eng_done high. A STOP command carries eng_start = 0, eng_ack_out = 0 and eng_tx = 0.
- R3: A normal read issues write {dev_addr,0} with START, then write offset without START. After that it leaves eng_req low for exactly GAP_CYCLES cycles and issues write {dev_addr,1} with START. No STOP comes between these commands.
- R4: A legacy read issues a single write {offset[6:0],1} with START and then goes straight to the data bytes.
- R5: A read of len bytes issues len read commands with eng_start = 0, eng_tx = 0 and eng_ack_out = 1 on all but the last, which has eng_ack_out = 0, and then a STOP. Each received byte appears on rdata with rdata_valid high for one cycle, the cycle after its eng_done.
- R6: A refused acknowledge on any addressing byte (device byte, offset byte, legacy byte, repeated-start byte) is followed by one STOP. The transfer then ends with done and error high.
- R7: A write is split into chunks of min(remaining, 4) bytes. Each chunk starts with write {dev_addr,0} with START and then the current offset (legacy: write {offset[6:0],0} with START only). The offset advances by one per byte written and wraps modulo 256. Every chunk ends with a STOP.
- R8: After each chunk STOP, the block issues write {dev_addr,1} with START. A refused poll is followed by a STOP and a new poll. When POLL_MAX polls in a row are refused, the transfer ends with done and error after the last poll STOP.
- R9: After an accepted poll, one read command with eng_ack_out = 0 and then a STOP are issued. That byte never appears on rdata. The next chunk, or done, follows.
- R10: A refused acknowledge on a write data byte is followed by one STOP. The transfer then ends with done and error high.
- R11: A data-byte command is requested only while wdata_valid is high, and it carries wdata. wdata_ready is high only in the cycle its eng_done arrives, so each byte is consumed exactly once.
- R12: A go with len = 0 produces done, with error low, in the next cycle and no command.
- R13: done is a one-cycle pulse, error is high only together with done, and no command is requested while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a transfer (honoured when idle) |
| wr_mode | input | 1 | 1 = block write, 0 = block read |
| legacy | input | 1 | Fold offset into the first byte |
| dev_addr | input | 7 | Target device address |
| offset | input | 8 | Starting register offset |
| len | input | LEN_W | Byte count |
| wdata | input | 8 | Write data byte |
| wdata_valid | input | 1 | Write data available |
| wdata_ready | output | 1 | Write data byte consumed |
| rdata | output | 8 | Read data byte |
| rdata_valid | output | 1 | rdata holds a new byte |
| eng_req | output | 1 | Command request to byte engine |
| eng_op | output | 2 | 0 write byte, 1 read byte, 2 STOP |
| eng_start | output | 1 | Precede write with START |
| eng_tx | output | 8 | Byte to send |
| eng_ack_out | output | 1 | Acknowledge to give after a read byte |
| eng_done | input | 1 | Command finished (one cycle) |
| eng_ack | input | 1 | Target acknowledged the written byte |
| eng_rx | input | 8 | Byte received by a read command |
| done | output | 1 | Transfer finished (pulse) |
| error | output | 1 | Transfer failed (with done) |

## Verification
The hardest state to reach is exhausting the poll budget: the device has to refuse exactly POLL_MAX polls in a row after a chunk. An off-by-one in the retry count shows up only at that boundary. The bench's engine model holds a per-chunk refusal count. One write runs with 100 refusals and must fail after the hundredth poll STOP. A second runs with 99 refusals and must succeed. Further runs inject a refusal at a chosen command index, which lands on the offset byte, the repeated start and a data byte in turn. Write data arrives with stall gaps, so the data command has to follow wdata_valid.

// File: rtl/eetc_pkg.sv
// Shared types for the EEPROM transfer sequencer: byte-engine command
// codes and sequencer states.
package eetc_pkg;

    typedef enum logic [1:0] {
        ENG_WRITE = 2'd0,
        ENG_READ  = 2'd1,
        ENG_STOP  = 2'd2
    } eng_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_OFFS,
        S_GAP,
        S_RADDR,
        S_RDATA,
        S_WDATA,
        S_WSTOP,
        S_POLL,
        S_PSTOP,
        S_PREAD,
        S_PRSTOP,
        S_STOP_OK,
        S_STOP_ERR
    } seq_st_e;

endpackage

// File: rtl/eetc_down_ctr.sv
// Loadable down-counter that stops at zero.
// Assumes load has priority over dec; at_one flags the final count.
module eetc_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    logic [W-1:0] cnt;

    // Count register: load, else decrement down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign at_one = (cnt == W'(1));
endmodule

// File: rtl/eetc_seq.sv
// Transfer sequencer: walks through the addressing, data, chunk and poll
// phases and issues one byte-engine command at a time.
// Assumes the engine answers each request with a one-cycle eng_done, and
// that wdata stays stable while wdata_valid is high until wdata_ready.
module eetc_seq
    import eetc_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CHUNK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             wr_mode,
    input  logic             legacy,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       offset,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wdata,
    input  logic             wdata_valid,
    output logic             wdata_ready,
    output logic [7:0]       rdata,
    output logic             rdata_valid,
    output logic             eng_req,
    output eng_op_e          eng_op,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    output logic             eng_ack_out,
    input  logic             eng_done,
    input  logic             eng_ack,
    input  logic [7:0]       eng_rx,
    output logic             gap_load,
    output logic             gap_dec,
    input  logic             gap_at_one,
    output logic             poll_load,
    output logic             poll_dec,
    input  logic             poll_at_one,
    output logic             idle,
    output logic             done,
    output logic             error
);
    localparam int CHUNK_W = $clog2(CHUNK + 1);

    seq_st_e            st;
    logic [LEN_W-1:0]   rem_q;
    logic [7:0]         off_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic [CHUNK_W-1:0] chunk_first;
    logic [6:0]         dev_q;
    logic               leg_q;
    logic               wr_q;

    // Size of the next chunk: the remainder, capped at CHUNK.
    always_comb begin
        chunk_first = (rem_q < LEN_W'(CHUNK)) ? CHUNK_W'(rem_q) : CHUNK_W'(CHUNK);
    end

    // Command presented to the byte engine in each state.
    always_comb begin
        eng_req     = 1'b0;
        eng_op      = ENG_WRITE;
        eng_start   = 1'b0;
        eng_tx      = '0;
        eng_ack_out = 1'b0;
        wdata_ready = 1'b0;
        unique case (st)
            S_ADDR: begin
                eng_req   = 1'b1;
                eng_start = 1'b1;
                eng_tx    = leg_q ? {off_q[6:0], ~wr_q} : {dev_q, 1'b0};
            end
            S_OFFS: begin
                eng_req = 1'b1;
                eng_tx  = off_q;
            end
            S_RADDR, S_POLL: begin
                eng_req   = 1'b1;
                eng_start = 1'b1;
                eng_tx    = {dev_q, 1'b1};
            end
            S_RDATA: begin
                eng_req     = 1'b1;
                eng_op      = ENG_READ;
                eng_ack_out = (rem_q != LEN_W'(1));
            end
            S_PREAD: begin
                eng_req = 1'b1;
                eng_op  = ENG_READ;
            end
            S_WDATA: begin
                eng_req     = wdata_valid;
                eng_tx      = wdata;
                wdata_ready = eng_done;
            end
            S_WSTOP, S_PSTOP, S_PRSTOP, S_STOP_OK, S_STOP_ERR: begin
                eng_req = 1'b1;
                eng_op  = ENG_STOP;
            end
            default: ;
        endcase
    end

    // Counter controls for the restart gap and the poll budget.
    assign gap_load  = (st == S_OFFS) && eng_done && eng_ack && !wr_q;
    assign gap_dec   = (st == S_GAP);
    assign poll_load = (st == S_WSTOP) && eng_done;
    assign poll_dec  = (st == S_PSTOP) && eng_done;
    assign idle      = (st == S_IDLE);

    // State, transfer context and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            rem_q       <= '0;
            off_q       <= '0;
            chunk_q     <= '0;
            dev_q       <= '0;
            leg_q       <= 1'b0;
            wr_q        <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
            done        <= 1'b0;
            error       <= 1'b0;
        end else begin
            rdata_valid <= 1'b0;
            done        <= 1'b0;
            error       <= 1'b0;
            unique case (st)
                S_IDLE: if (go) begin
                    dev_q <= dev_addr;
                    off_q <= offset;
                    rem_q <= len;
                    leg_q <= legacy;
                    wr_q  <= wr_mode;
                    if (len == '0) done <= 1'b1;
                    else           st   <= S_ADDR;
                end
                S_ADDR: if (eng_done) begin
                    chunk_q <= chunk_first;
                    if (!eng_ack)   st <= S_STOP_ERR;
                    else if (leg_q) st <= wr_q ? S_WDATA : S_RDATA;
                    else            st <= S_OFFS;
                end
                S_OFFS: if (eng_done) begin
                    if (!eng_ack)  st <= S_STOP_ERR;
                    else           st <= wr_q ? S_WDATA : S_GAP;
                end
                S_GAP: if (gap_at_one) st <= S_RADDR;
                S_RADDR: if (eng_done) st <= eng_ack ? S_RDATA : S_STOP_ERR;
                S_RDATA: if (eng_done) begin
                    rdata       <= eng_rx;
                    rdata_valid <= 1'b1;
                    rem_q       <= rem_q - 1'b1;
                    if (rem_q == LEN_W'(1)) st <= S_STOP_OK;
                end
                S_WDATA: if (eng_done) begin
                    if (!eng_ack) begin
                        st <= S_STOP_ERR;
                    end else begin
                        rem_q   <= rem_q - 1'b1;
                        off_q   <= off_q + 1'b1;
                        chunk_q <= chunk_q - 1'b1;
                        if (chunk_q == CHUNK_W'(1)) st <= S_WSTOP;
                    end
                end
                S_WSTOP: if (eng_done) st <= S_POLL;
                S_POLL:  if (eng_done) st <= eng_ack ? S_PREAD : S_PSTOP;
                S_PSTOP: if (eng_done) begin
                    if (poll_at_one) begin
                        st    <= S_IDLE;
                        done  <= 1'b1;
                        error <= 1'b1;
                    end else begin
                        st <= S_POLL;
                    end
                end
                S_PREAD: if (eng_done) st <= S_PRSTOP;
                S_PRSTOP: if (eng_done) begin
                    if (rem_q == '0) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= S_ADDR;
                    end
                end
                S_STOP_OK: if (eng_done) begin
                    st   <= S_IDLE;
                    done <= 1'b1;
                end
                S_STOP_ERR: if (eng_done) begin
                    st    <= S_IDLE;
                    done  <= 1'b1;
                    error <= 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eetc_xfer.sv
// Top of the EEPROM transfer sequencer: the state machine plus a
// restart-gap timer and a poll-budget counter.
// Assumes GAP_CYCLES >= 1, POLL_MAX >= 1 and CHUNK >= 1.
module eetc_xfer
    import eetc_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int CHUNK      = 4,
    parameter int POLL_MAX   = 100,
    parameter int GAP_CYCLES = 7500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             wr_mode,
    input  logic             legacy,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       offset,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wdata,
    input  logic             wdata_valid,
    output logic             wdata_ready,
    output logic [7:0]       rdata,
    output logic             rdata_valid,
    output logic             eng_req,
    output logic [1:0]       eng_op,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    output logic             eng_ack_out,
    input  logic             eng_done,
    input  logic             eng_ack,
    input  logic [7:0]       eng_rx,
    output logic             done,
    output logic             error
);
    localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    eng_op_e seq_op;
    logic    gap_load, gap_dec, gap_at_one;
    logic    poll_load, poll_dec, poll_at_one;
    logic    seq_idle;

    assign eng_op = seq_op;

    eetc_seq #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .wr_mode(wr_mode), .legacy(legacy),
        .dev_addr(dev_addr), .offset(offset), .len(len),
        .wdata(wdata), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
        .rdata(rdata), .rdata_valid(rdata_valid),
        .eng_req(eng_req), .eng_op(seq_op), .eng_start(eng_start), .eng_tx(eng_tx),
        .eng_ack_out(eng_ack_out), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx),
        .gap_load(gap_load), .gap_dec(gap_dec), .gap_at_one(gap_at_one),
        .poll_load(poll_load), .poll_dec(poll_dec), .poll_at_one(poll_at_one),
        .idle(seq_idle), .done(done), .error(error)
    );

    eetc_down_ctr #(.W(GAP_W)) u_gap_ctr (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .load_val(GAP_W'(GAP_CYCLES)), .dec(gap_dec), .at_one(gap_at_one)
    );

    eetc_down_ctr #(.W(POLL_W)) u_poll_ctr (
        .clk(clk), .rst_n(rst_n), .load(poll_load),
        .load_val(POLL_W'(POLL_MAX)), .dec(poll_dec), .at_one(poll_at_one)
    );
endmodule

// File: rtl/eetc_xfer_chk.sv
// Property checker for the EEPROM transfer sequencer, bound to its top.
// Relates the engine command port, the data handshakes and the result.
module eetc_xfer_chk
    import eetc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [LEN_W-1:0] len,
    input logic             seq_idle,
    input logic             eng_req,
    input logic [1:0]       eng_op,
    input logic             eng_start,
    input logic [7:0]       eng_tx,
    input logic             eng_ack_out,
    input logic             eng_done,
    input logic             wdata_ready,
    input logic             rdata_valid,
    input logic             done,
    input logic             error
);
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_tx)
            && $stable(eng_start) && $stable(eng_ack_out)); // R2

    AST_STOP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_op == ENG_STOP |-> !eng_start && !eng_ack_out && eng_tx == 8'h00); // R2

    AST_READ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_op == ENG_READ |-> !eng_start); // R5

    AST_RDATA_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(eng_done) && $past(eng_op) == ENG_READ); // R5

    AST_WREADY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_ready |-> eng_done && eng_req && eng_op == ENG_WRITE && !eng_start); // R11

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        go && seq_idle && len == '0 |=> done && !error && !eng_req); // R12

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R13

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !eng_req); // R13
endmodule

bind eetc_xfer eetc_xfer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .len(len), .seq_idle(seq_idle),
    .eng_req(eng_req), .eng_op(eng_op), .eng_start(eng_start), .eng_tx(eng_tx),
    .eng_ack_out(eng_ack_out), .eng_done(eng_done), .wdata_ready(wdata_ready),
    .rdata_valid(rdata_valid), .done(done), .error(error)
);

// File: tb/eetc_xfer_bench.sv
// Bench: behavioural byte-engine/device model plus an expected command
// list built from the requirements, compared on every clock.
module eetc_xfer_bench;
    localparam int LEN_W = 8;
    localparam int CHUNK = 4;
    localparam int POLL  = 100;
    localparam int GAP   = 6;
    localparam int LAT   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic go = 0, wr_mode = 0, legacy = 0;
    logic [6:0] dev_addr = 0;
    logic [7:0] offset = 0;
    logic [LEN_W-1:0] len = 0;
    logic [7:0] wdata = 0;
    logic wdata_valid = 0;
    logic wdata_ready;
    logic [7:0] rdata;
    logic rdata_valid;
    logic eng_req, eng_start, eng_ack_out;
    logic [1:0] eng_op;
    logic [7:0] eng_tx;
    logic eng_done = 0, eng_ack = 0;
    logic [7:0] eng_rx = 0;
    logic done, error;

    eetc_xfer #(.LEN_W(LEN_W), .CHUNK(CHUNK), .POLL_MAX(POLL), .GAP_CYCLES(GAP)) u_eetc_xfer (
        .clk(clk), .rst_n(rst_n), .go(go), .wr_mode(wr_mode), .legacy(legacy),
        .dev_addr(dev_addr), .offset(offset), .len(len),
        .wdata(wdata), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
        .rdata(rdata), .rdata_valid(rdata_valid),
        .eng_req(eng_req), .eng_op(eng_op), .eng_start(eng_start), .eng_tx(eng_tx),
        .eng_ack_out(eng_ack_out), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx),
        .done(done), .error(error)
    );

    int n_chk = 0, n_err = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pk(input int op, input bit st, input bit ao, input logic [7:0] b);
        return (op << 10) | (int'(st) << 9) | (int'(ao) << 8) | int'(b);
    endfunction

    // Expected command list and outcome
    int exp_code[$];
    int exp_idle[$];
    string exp_tag[$];
    logic [7:0] exp_rd[$];
    bit exp_err;
    int exp_wused;
    int g_idx, g_pl, g_nack;

    // Scenario shared by model and generator
    bit wtest;
    logic [6:0] s_dev;
    int s_nack, s_pn, s_stall;
    logic [7:0] wbytes[$];

    // Model state
    bit m_busy;
    int m_cnt, cmd_idx, poll_left, idle_run, wptr, stall_left;
    bit consumed, seen_done, seen_err;
    logic [7:0] got_rd[$];

    function automatic bit put(input int op, input bit st, input bit ao,
                               input logic [7:0] b, input int idle, input string tag);
        bit ack;
        exp_code.push_back(pk(op, st, ao, b));
        exp_idle.push_back(idle);
        exp_tag.push_back(tag);
        ack = (g_idx != g_nack);
        if (wtest && op == 0 && st && b == {s_dev, 1'b1}) begin
            if (g_pl > 0) begin ack = 0; g_pl--; end
            else if (ack) g_pl = s_pn;
        end
        g_idx++;
        return ack;
    endfunction

    task automatic gen(input bit wr, input bit leg, input int n, input logic [7:0] off);
        int rem, polls, c;
        logic [7:0] o;
        bit ok;
        exp_code.delete(); exp_idle.delete(); exp_tag.delete(); exp_rd.delete();
        exp_err = 0; exp_wused = 0; g_idx = 0; g_pl = s_pn; g_nack = s_nack;
        o = off;
        if (n == 0) return;
        if (!wr) begin
            if (leg) ok = put(0, 1, 0, {o[6:0], 1'b1}, -1, "R4");
            else begin
                ok = put(0, 1, 0, {s_dev, 1'b0}, -1, "R3");
                if (ok) ok = put(0, 0, 0, o, -1, "R3");
                if (ok) ok = put(0, 1, 0, {s_dev, 1'b1}, GAP, "R3");
            end
            if (!ok) begin void'(put(2, 0, 0, 8'h00, -1, "R6")); exp_err = 1; return; end
            for (int i = 0; i < n; i++) begin
                exp_rd.push_back(8'h5A ^ g_idx[7:0]);
                void'(put(1, 0, (i != n - 1), 8'h00, -1, "R5"));
            end
            void'(put(2, 0, 0, 8'h00, -1, "R5"));
        end else begin
            rem = n;
            while (rem > 0) begin
                if (leg) ok = put(0, 1, 0, {o[6:0], 1'b0}, -1, "R7");
                else begin
                    ok = put(0, 1, 0, {s_dev, 1'b0}, -1, "R7");
                    if (ok) ok = put(0, 0, 0, o, -1, "R7");
                end
                if (!ok) begin void'(put(2, 0, 0, 8'h00, -1, "R6")); exp_err = 1; return; end
                c = (rem < CHUNK) ? rem : CHUNK;
                for (int j = 0; j < c; j++) begin
                    ok = put(0, 0, 0, wbytes[exp_wused], -1, "R11");
                    exp_wused++;
                    if (!ok) begin void'(put(2, 0, 0, 8'h00, -1, "R10")); exp_err = 1; return; end
                    o++;
                    rem--;
                end
                void'(put(2, 0, 0, 8'h00, -1, "R7"));
                polls = 0;
                do begin
                    ok = put(0, 1, 0, {s_dev, 1'b1}, -1, "R8");
                    if (!ok) begin
                        void'(put(2, 0, 0, 8'h00, -1, "R8"));
                        polls++;
                        if (polls == POLL) begin exp_err = 1; return; end
                    end
                end while (!ok);
                void'(put(1, 0, 0, 8'h00, -1, "R9"));
                void'(put(2, 0, 0, 8'h00, -1, "R9"));
            end
        end
    endtask

    // Engine/device model and per-clock comparison
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 0;
            if (rst_n) begin
                if (consumed) begin wptr++; consumed = 0; stall_left = s_stall; end
                if (wtest && wptr < wbytes.size() && stall_left == 0) begin
                    wdata_valid = 1; wdata = wbytes[wptr];
                end else begin
                    wdata_valid = 0;
                    if (stall_left > 0) stall_left--;
                end
                #1;
                if (eng_req) begin
                    int cur;
                    cur = pk(int'(eng_op), eng_start, eng_ack_out, eng_tx);
                    if (exp_code.size() == 0) begin
                        check(0, "R2", "unexpected command", cur, 0);
                    end else begin
                        check(cur == exp_code[0], exp_tag[0], "command", cur, exp_code[0]);
                        if (!m_busy && exp_idle[0] >= 0)
                            check(idle_run == exp_idle[0], "R3", "idle cycles before restart",
                                  idle_run, exp_idle[0]);
                    end
                    if (!m_busy) begin m_busy = 1; m_cnt = LAT; end
                    m_cnt--;
                    if (m_cnt == 0) begin
                        bit ack;
                        ack = (cmd_idx != s_nack);
                        if (wtest && eng_op == 2'd0 && eng_start && eng_tx == {s_dev, 1'b1}) begin
                            if (poll_left > 0) begin ack = 0; poll_left--; end
                            else if (ack) poll_left = s_pn;
                        end
                        eng_ack = ack;
                        eng_rx = 8'h5A ^ cmd_idx[7:0];
                        eng_done = 1;
                        cmd_idx++;
                        m_busy = 0;
                        idle_run = 0;
                        if (exp_code.size() > 0) begin
                            void'(exp_code.pop_front()); void'(exp_idle.pop_front());
                            void'(exp_tag.pop_front());
                        end
                    end
                end else begin
                    idle_run++;
                end
                #1;
                if (wdata_ready) consumed = 1;
                if (rdata_valid) got_rd.push_back(rdata);
                if (done) begin seen_done = 1; seen_err = error; end
            end
        end
    end

    task automatic run(input bit wr, input bit leg, input int n, input logic [6:0] dev,
                       input logic [7:0] off, input int nack, input int pn, input int stall,
                       input string tag, output int lat);
        wtest = wr; s_dev = dev; s_nack = nack; s_pn = pn; s_stall = stall;
        wbytes.delete();
        for (int i = 0; i < n; i++) wbytes.push_back(8'h30 + 8'(i * 7));
        gen(wr, leg, n, off);
        got_rd.delete();
        seen_done = 0; seen_err = 0; wptr = 0; consumed = 0; stall_left = 0;
        cmd_idx = 0; poll_left = pn; idle_run = 0; m_busy = 0;
        @(negedge clk);
        go = 1; wr_mode = wr; legacy = leg; dev_addr = dev; offset = off; len = LEN_W'(n);
        @(negedge clk);
        go = 0;
        lat = 1;
        #3;
        while (!seen_done && lat < 20000) begin
            @(negedge clk); #3;
            lat++;
        end
        check(seen_done, tag, "transfer finished", int'(seen_done), 1);
        repeat (2) @(negedge clk);
        check(exp_code.size() == 0, tag, "commands left unissued", exp_code.size(), 0);
        check(seen_err == exp_err, exp_err ? "R6" : "R13", "error result", int'(seen_err), int'(exp_err));
        check(got_rd.size() == exp_rd.size(), "R5", "read byte count", got_rd.size(), exp_rd.size());
        for (int i = 0; i < got_rd.size() && i < exp_rd.size(); i++)
            check(got_rd[i] == exp_rd[i], "R5", "read byte", got_rd[i], exp_rd[i]);
        if (wr) check(wptr == exp_wused, "R11", "write bytes consumed", wptr, exp_wused);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int lat;
        wtest = 0; s_nack = -1; s_pn = 0; s_stall = 0; s_dev = 0;
        repeat (3) @(negedge clk);
        check(!eng_req && !wdata_ready && !rdata_valid && !done && !error, "R1", "reset outputs",
              {eng_req, wdata_ready, rdata_valid, done, error}, 0);
        rst_n = 1;
        // R12: zero length, read and write
        run(0, 0, 0, 7'h50, 8'h10, -1, 0, 0, "R12", lat);
        check(lat == 1, "R12", "zero-length read latency", lat, 1);
        run(1, 0, 0, 7'h50, 8'h10, -1, 0, 0, "R12", lat);
        check(lat == 1, "R12", "zero-length write latency", lat, 1);
        // R3 R5: normal reads
        run(0, 0, 5, 7'h50, 8'h10, -1, 0, 0, "R3", lat);
        run(0, 0, 1, 7'h2B, 8'hF0, -1, 0, 0, "R5", lat);
        // R4: legacy read
        run(0, 1, 3, 7'h50, 8'h23, -1, 0, 0, "R4", lat);
        // R6: refusal on device byte, offset byte, restart byte
        run(0, 0, 4, 7'h50, 8'h10, 0, 0, 0, "R6", lat);
        run(0, 0, 4, 7'h50, 8'h10, 1, 0, 0, "R6", lat);
        run(0, 0, 4, 7'h50, 8'h10, 2, 0, 0, "R6", lat);
        // R7 R8 R9 R11: chunked write with offset wrap, polls refused, stalls
        run(1, 0, 10, 7'h50, 8'hFC, -1, 3, 2, "R7", lat);
        // R7: legacy write
        run(1, 1, 5, 7'h51, 8'h40, -1, 1, 0, "R7", lat);
        // R10: refusal on a data byte
        run(1, 0, 6, 7'h50, 8'h00, 3, 0, 1, "R10", lat);
        // R6: refusal on write offset byte
        run(1, 0, 3, 7'h50, 8'h08, 1, 0, 0, "R6", lat);
        // R8: poll budget boundary, success at 99 refusals, failure at 100
        run(1, 0, 4, 7'h50, 8'h20, -1, POLL - 1, 0, "R8", lat);
        run(1, 0, 2, 7'h50, 8'h20, -1, POLL, 0, "R8", lat);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule